// File: doc/BRIEF.md
# Home Directory Controller with Upgrade Rejection

This block is the home-node directory controller for one slice of distributed memory. Requests arrive on a single request channel: read (GetS), write (GetM), upgrade (shared-to-modified permission with no data), and a completion message (Done) that a requestor sends once its transaction is over. Each cycle the controller takes at most one request. It looks up that block's directory entry and produces one reply to the requestor. When other caches are involved, it also produces one multicast forward or invalidation. Both are registered. Only two message classes exist. Replies, rejections and backoffs leave on the response class. Forwards and invalidations are request-class traffic.

Each directory entry has a 16-bit sharer field, interpreted according to a format bit. In pointer format the field holds up to three 4-bit node numbers. When a fourth node joins, the entry changes to a coarse vector of eight bits, each covering a pair of nodes. A read that finds the block exclusive at another node gets speculative memory data, and the exclusive holder also receives a forward. The holder may have dropped the line silently, so the requestor waits for both the memory data and the holder's reply. An upgrade from a node that is no longer recorded as a sharer is rejected, and that node must retry with a full GetM. A block with a transaction in flight is marked busy, and requests to it are rejected rather than queued. When the forward path is blocked, the controller sends the requestor a backoff that lists the nodes to contact, and sends no forward itself.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset both valid outputs are low and every block is Unowned. A GetS to an untouched block therefore gets an exclusive data grant.
- R2: A GetS or GetM to an Unowned block replies with kind 1 (exclusive data) and ack count 0, with no forward. The requestor becomes the exclusive holder. Memory data is 0xD0000000 + addr*0x101.
- R3: A GetS to a Shared block replies with kind 0 (shared data) and memory data, and adds the requestor to the sharers.
- R4: A GetS to a block held exclusively by another node replies with kind 2 (speculative memory data). It sends forward kind 0 (forwarded read) to the holder alone, and the entry becomes Shared by both nodes and busy.
- R5: A GetM to a Shared block replies with kind 1 and an ack count equal to the number of invalidated nodes. It sends forward kind 2 (invalidate) to every recorded sharer except the requestor.
- R6: A GetM to a block held exclusively by another node replies with kind 3 (ack count, no data) and count 0. It sends forward kind 1 (forwarded write) to the holder, and the requestor becomes the holder with the block busy.
- R7: An Upgrade from a recorded sharer of a Shared block replies with kind 3, counting the other sharers, and invalidates them. No data moves.
- R8: An Upgrade from a node that is not a recorded sharer of a Shared block replies with kind 4 (reject), sends no forward, and leaves the entry unchanged.
- R9: Any GetS, GetM or Upgrade to a busy block replies with kind 4 and sends no forward. A Done to that block from any node clears busy.
- R10: Pointer format stores up to three sharers exactly. A fourth distinct sharer switches the entry to a vector in which bit g covers nodes 2g and 2g+1, and invalidations then reach every node of each marked pair except the requestor.
- R11: While fwdBlocked is high, a request that would forward replies with kind 5 (backoff) instead. The backoff carries the would-be target mask in rspTargets, the same ack count and the memory data, sends no forward, and updates the entry as usual.
- R12: Replies and forwards appear one cycle after the request, with rspDest and fwdReq equal to the requestor and the addresses echoed. Done and idle cycles produce nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 2 | 0 GetS, 1 GetM, 2 Upgrade, 3 Done |
| reqSrc | input | 4 | Requesting node |
| reqAddr | input | 4 | Block index |
| fwdBlocked | input | 1 | Forward path cannot accept traffic |
| rspValid | output | 1 | Response-class message valid |
| rspKind | output | 3 | Reply kind, encoded as in the requirements |
| rspDest | output | 4 | Destination node of the reply |
| rspAddr | output | 4 | Block index of the reply |
| rspData | output | 32 | Memory data of the block |
| rspAckCnt | output | 5 | Number of acks the requestor must collect |
| rspTargets | output | 16 | Node mask to contact (backoff only, else 0) |
| fwdValid | output | 1 | Forward or invalidation valid |
| fwdKind | output | 2 | 0 forwarded read, 1 forwarded write, 2 invalidate |
| fwdMask | output | 16 | Target nodes, one bit per node |
| fwdReq | output | 4 | Original requestor |
| fwdAddr | output | 4 | Block index |

## Verification
Every reply and forward is registered once, so each result belongs to the rising edge that samples the request. An entry update is visible to the very next request. The bench drives each request on a falling edge and reads all outputs on the following falling edge, one full cycle later. It then issues the next request, which checks the previous entry update with no extra wait. Done and idle cycles are checked at the same point to confirm that both valid outputs stay low.

// File: rtl/dir_home_pkg.sv
package dir_home_pkg;
  localparam int NODE_W   = 4;
  localparam int NODES    = 1 << NODE_W;
  localparam int FIELD_W  = 16;
  localparam int PTRS     = 3;
  localparam int GROUPS   = 8;
  localparam int GROUP_SZ = NODES / GROUPS;
  localparam int ADDR_W   = 4;
  localparam int BLOCKS   = 1 << ADDR_W;
  localparam int DATA_W   = 32;
  localparam int ACK_W    = NODE_W + 1;
  localparam int CNT_W    = $clog2(PTRS + 1);
  localparam logic [DATA_W-1:0] MEM_BASE = 32'hD000_0000;
  localparam logic [DATA_W-1:0] MEM_STEP = 32'h0000_0101;

  typedef enum logic [1:0] {REQ_GETS, REQ_GETM, REQ_UPGRADE, REQ_DONE} reqKind_e;
  typedef enum logic [2:0] {RSP_DATA_SHARED, RSP_DATA_EXCL, RSP_DATA_SPEC,
                            RSP_ACK_COUNT, RSP_NACK, RSP_BACKOFF} rspKind_e;
  typedef enum logic [1:0] {FWD_GETS, FWD_GETM, FWD_INV} fwdKind_e;
  typedef enum logic [1:0] {ST_UNOWNED, ST_SHARED, ST_EXCL} dirState_e;

  typedef struct packed {
    dirState_e          state;
    logic               busy;
    logic               vecMode;
    logic [CNT_W-1:0]   ptrCnt;
    logic [FIELD_W-1:0] field;
  } dirEntry_t;

  typedef struct packed {
    logic               entryWe;
    dirEntry_t          newEntry;
    logic               rspValid;
    rspKind_e           rspKind;
    logic [ACK_W-1:0]   ackCnt;
    logic [NODES-1:0]   targets;
    logic               fwdValid;
    fwdKind_e           fwdKind;
    logic [NODES-1:0]   fwdMask;
  } ctrlStrobe_t;

  function automatic logic [NODES-1:0] sharerMask(input dirEntry_t e);
    logic [NODES-1:0] m;
    m = '0;
    if (e.vecMode) begin
      for (int n = 0; n < NODES; n++) m[n] = e.field[n / GROUP_SZ];
    end else begin
      for (int i = 0; i < PTRS; i++)
        if (i < int'(e.ptrCnt)) m[e.field[i*NODE_W +: NODE_W]] = 1'b1;
    end
    return m;
  endfunction

  function automatic dirEntry_t addSharer(input dirEntry_t e, input logic [NODE_W-1:0] node);
    dirEntry_t r;
    logic [NODES-1:0] m;
    r = e;
    m = sharerMask(e);
    if (e.vecMode) begin
      r.field[int'(node) / GROUP_SZ] = 1'b1;
    end else if (!m[node]) begin
      if (int'(e.ptrCnt) < PTRS) begin
        r.field[int'(e.ptrCnt)*NODE_W +: NODE_W] = node;
        r.ptrCnt = e.ptrCnt + 1'b1;
      end else begin
        m[node] = 1'b1;
        r.field = '0;
        for (int g = 0; g < GROUPS; g++) r.field[g] = |m[g*GROUP_SZ +: GROUP_SZ];
        r.vecMode = 1'b1;
        r.ptrCnt = '0;
      end
    end
    return r;
  endfunction

  function automatic dirEntry_t ownedBy(input logic [NODE_W-1:0] node, input logic busy);
    dirEntry_t r;
    r = '0;
    r.state = ST_EXCL;
    r.busy = busy;
    r.ptrCnt = CNT_W'(1);
    r.field[NODE_W-1:0] = node;
    return r;
  endfunction
endpackage

// File: rtl/dir_home_control.sv
module dir_home_control
  import dir_home_pkg::*;
(
  input  logic              reqValid,
  input  reqKind_e          reqKind,
  input  logic [NODE_W-1:0] reqSrc,
  input  logic              fwdBlocked,
  input  dirEntry_t         curEntry,
  output ctrlStrobe_t       strobe
);
  logic [NODES-1:0] curMask, srcBit, others, ownerBit;
  logic [NODE_W-1:0] owner;
  logic [ACK_W-1:0] otherCnt;

  always_comb begin
    curMask  = sharerMask(curEntry);
    srcBit   = NODES'(1) << reqSrc;
    others   = curMask & ~srcBit;
    owner    = curEntry.field[NODE_W-1:0];
    ownerBit = NODES'(1) << owner;
    otherCnt = ACK_W'($countones(others));
  end

  always_comb begin
    strobe = '0;
    strobe.newEntry = curEntry;
    strobe.rspKind  = RSP_NACK;
    if (reqValid) begin
      if (reqKind == REQ_DONE) begin
        strobe.entryWe = curEntry.busy;
        strobe.newEntry.busy = 1'b0;
      end else begin
        strobe.rspValid = 1'b1;
        if (!curEntry.busy) begin
          unique case (reqKind)
            REQ_GETS: begin
              if (curEntry.state == ST_UNOWNED ||
                  (curEntry.state == ST_EXCL && owner == reqSrc)) begin
                strobe.rspKind  = RSP_DATA_EXCL;
                strobe.entryWe  = 1'b1;
                strobe.newEntry = ownedBy(reqSrc, 1'b0);
              end else if (curEntry.state == ST_SHARED) begin
                strobe.rspKind  = RSP_DATA_SHARED;
                strobe.entryWe  = 1'b1;
                strobe.newEntry = addSharer(curEntry, reqSrc);
              end else begin
                strobe.rspKind  = RSP_DATA_SPEC;
                strobe.fwdValid = 1'b1;
                strobe.fwdKind  = FWD_GETS;
                strobe.fwdMask  = ownerBit;
                strobe.entryWe  = 1'b1;
                strobe.newEntry = '0;
                strobe.newEntry.state = ST_SHARED;
                strobe.newEntry.busy  = 1'b1;
                strobe.newEntry.ptrCnt = CNT_W'(2);
                strobe.newEntry.field[NODE_W-1:0] = owner;
                strobe.newEntry.field[2*NODE_W-1:NODE_W] = reqSrc;
              end
            end
            REQ_GETM: begin
              strobe.entryWe = 1'b1;
              if (curEntry.state == ST_UNOWNED ||
                  (curEntry.state == ST_EXCL && owner == reqSrc)) begin
                strobe.rspKind  = RSP_DATA_EXCL;
                strobe.newEntry = ownedBy(reqSrc, 1'b0);
              end else if (curEntry.state == ST_SHARED) begin
                strobe.rspKind  = RSP_DATA_EXCL;
                strobe.ackCnt   = otherCnt;
                strobe.fwdValid = |others;
                strobe.fwdKind  = FWD_INV;
                strobe.fwdMask  = others;
                strobe.newEntry = ownedBy(reqSrc, |others);
              end else begin
                strobe.rspKind  = RSP_ACK_COUNT;
                strobe.fwdValid = 1'b1;
                strobe.fwdKind  = FWD_GETM;
                strobe.fwdMask  = ownerBit;
                strobe.newEntry = ownedBy(reqSrc, 1'b1);
              end
            end
            REQ_UPGRADE: begin
              if (curEntry.state == ST_SHARED && curMask[reqSrc]) begin
                strobe.rspKind  = RSP_ACK_COUNT;
                strobe.ackCnt   = otherCnt;
                strobe.fwdValid = |others;
                strobe.fwdKind  = FWD_INV;
                strobe.fwdMask  = others;
                strobe.entryWe  = 1'b1;
                strobe.newEntry = ownedBy(reqSrc, |others);
              end
            end
            default: ;
          endcase
        end
        if (strobe.fwdValid && fwdBlocked) begin
          strobe.rspKind  = RSP_BACKOFF;
          strobe.targets  = strobe.fwdMask;
          strobe.fwdValid = 1'b0;
          strobe.fwdMask  = '0;
        end
      end
    end
  end
endmodule

// File: rtl/dir_home_datapath.sv
module dir_home_datapath
  import dir_home_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [NODE_W-1:0] reqSrc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  ctrlStrobe_t       strobe,
  output dirEntry_t         curEntry,
  output logic              rspValid,
  output logic [2:0]        rspKind,
  output logic [NODE_W-1:0] rspDest,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [DATA_W-1:0] rspData,
  output logic [ACK_W-1:0]  rspAckCnt,
  output logic [NODES-1:0]  rspTargets,
  output logic              fwdValid,
  output logic [1:0]        fwdKind,
  output logic [NODES-1:0]  fwdMask,
  output logic [NODE_W-1:0] fwdReq,
  output logic [ADDR_W-1:0] fwdAddr
);
  dirEntry_t         dirTable [BLOCKS];
  logic [DATA_W-1:0] memArray [BLOCKS];

  assign curEntry = dirTable[reqAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < BLOCKS; b++) begin
        dirTable[b] <= '0;
        memArray[b] <= MEM_BASE + DATA_W'(b) * MEM_STEP;
      end
    end else if (reqValid && strobe.entryWe) begin
      dirTable[reqAddr] <= strobe.newEntry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspKind    <= '0;
      rspDest    <= '0;
      rspAddr    <= '0;
      rspData    <= '0;
      rspAckCnt  <= '0;
      rspTargets <= '0;
      fwdValid   <= 1'b0;
      fwdKind    <= '0;
      fwdMask    <= '0;
      fwdReq     <= '0;
      fwdAddr    <= '0;
    end else begin
      rspValid   <= strobe.rspValid;
      rspKind    <= strobe.rspKind;
      rspDest    <= reqSrc;
      rspAddr    <= reqAddr;
      rspData    <= memArray[reqAddr];
      rspAckCnt  <= strobe.ackCnt;
      rspTargets <= strobe.targets;
      fwdValid   <= strobe.fwdValid;
      fwdKind    <= strobe.fwdKind;
      fwdMask    <= strobe.fwdMask;
      fwdReq     <= reqSrc;
      fwdAddr    <= reqAddr;
    end
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_home_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [NODE_W-1:0] reqSrc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              fwdBlocked,
  output logic              rspValid,
  output logic [2:0]        rspKind,
  output logic [NODE_W-1:0] rspDest,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [DATA_W-1:0] rspData,
  output logic [ACK_W-1:0]  rspAckCnt,
  output logic [NODES-1:0]  rspTargets,
  output logic              fwdValid,
  output logic [1:0]        fwdKind,
  output logic [NODES-1:0]  fwdMask,
  output logic [NODE_W-1:0] fwdReq,
  output logic [ADDR_W-1:0] fwdAddr
);
  ctrlStrobe_t strobe;
  dirEntry_t   curEntry;

  dir_home_control u_control (
    .reqValid  (reqValid),
    .reqKind   (reqKind_e'(reqKind)),
    .reqSrc    (reqSrc),
    .fwdBlocked(fwdBlocked),
    .curEntry  (curEntry),
    .strobe    (strobe)
  );

  dir_home_datapath u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqSrc    (reqSrc),
    .reqAddr   (reqAddr),
    .strobe    (strobe),
    .curEntry  (curEntry),
    .rspValid  (rspValid),
    .rspKind   (rspKind),
    .rspDest   (rspDest),
    .rspAddr   (rspAddr),
    .rspData   (rspData),
    .rspAckCnt (rspAckCnt),
    .rspTargets(rspTargets),
    .fwdValid  (fwdValid),
    .fwdKind   (fwdKind),
    .fwdMask   (fwdMask),
    .fwdReq    (fwdReq),
    .fwdAddr   (fwdAddr)
  );
endmodule

// File: rtl/dir_home_ctrl_checker.sv
module dir_home_ctrl_checker
  import dir_home_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqKind,
  input logic [NODE_W-1:0] reqSrc,
  input logic              rspValid,
  input logic [2:0]        rspKind,
  input logic [NODE_W-1:0] rspDest,
  input logic [ACK_W-1:0]  rspAckCnt,
  input logic [NODES-1:0]  rspTargets,
  input logic              fwdValid,
  input logic [1:0]        fwdKind,
  input logic [NODES-1:0]  fwdMask,
  input logic [NODE_W-1:0] fwdReq
);
  AST_REPLY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($past(reqValid) && $past(reqKind) != 2'd3)); // R12
  AST_REPLY_DEST: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> rspDest == $past(reqSrc)); // R12
  AST_NACK_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == 3'd4) |-> !fwdValid); // R8
  AST_BACKOFF_LIST: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == 3'd5) |-> (!fwdValid && rspTargets != '0)); // R11
  AST_FWD_PAIRED: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> (rspValid && rspKind != 3'd4 && rspKind != 3'd5)); // R12
  AST_FWD_ONE_HOLDER: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && fwdKind != 2'd2) |-> $countones(fwdMask) == 1); // R4
  AST_INV_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && fwdKind == 2'd2) |-> int'(rspAckCnt) == $countones(fwdMask)); // R5
  AST_NO_SELF_FWD: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> !fwdMask[fwdReq]); // R10
endmodule

bind dir_home_ctrl dir_home_ctrl_checker u_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqSrc(reqSrc),
  .rspValid(rspValid), .rspKind(rspKind), .rspDest(rspDest), .rspAckCnt(rspAckCnt),
  .rspTargets(rspTargets), .fwdValid(fwdValid), .fwdKind(fwdKind), .fwdMask(fwdMask),
  .fwdReq(fwdReq)
);

// File: tb/dir_home_ctrl_bench.sv
module dir_home_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NUM_VEC    = 24;

  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  src;
    logic [3:0]  addr;
    logic        blk;
    logic        expV;
    logic [2:0]  expK;
    logic [4:0]  expA;
    logic        expF;
    logic [1:0]  expFK;
    logic [15:0] expM;
    logic [15:0] expT;
    logic [7:0]  tag;
  } vec_t;

  localparam vec_t VECS [NUM_VEC] = '{
    '{2'd0, 4'd1,  4'd1, 1'b0, 1'b1, 3'd1, 5'd0, 1'b0, 2'd0, 16'h0000, 16'h0000, 8'd2},  // R2
    '{2'd0, 4'd2,  4'd1, 1'b0, 1'b1, 3'd2, 5'd0, 1'b1, 2'd0, 16'h0002, 16'h0000, 8'd4},  // R4
    '{2'd0, 4'd3,  4'd1, 1'b0, 1'b1, 3'd4, 5'd0, 1'b0, 2'd0, 16'h0000, 16'h0000, 8'd9},  // R9
    '{2'd3, 4'd2,  4'd1, 1'b0, 1'b0, 3'd0, 5'd0, 1'b0, 2'd0, 16'h0000, 16'h0000, 8'd12}, // R12
    '{2'd0, 4'd3,  4'd1, 1'b0, 1'b1, 3'd0, 5'd0, 1'b0, 2'd0, 16'h0000, 16'h0000, 8'd3},  // R3
    '{2'd2, 4'd5,  4'd1, 1'b0, 1'b1, 3'd4, 5'd0, 1'b0, 2'd0, 16'h0000, 16'h0000, 8'd8},  // R8
    '{2'd2, 4'd2,  4'd1, 1'b0, 1'b1, 3'd3, 5'd2, 1'b1, 2'd2, 16'h000A, 16'h0000, 8'd7},  // R7
    '{2'd3, 4'd2,  4'd1, 1'b0, 1'b0, 3'd0, 5'd0, 1'b0, 2'd0, 16'h0000, 16'h0000, 8'd9},  // R9
    '{2'd2, 4'd1,  4'd1, 1'b0, 1'b1, 3'd4, 5'd0, 1'b0, 2'd0, 16'h0000, 16'h0000, 8'd8},  // R8
    '{2'd1, 4'd1,  4'd1, 1'b0, 1'b1, 3'd3, 5'd0, 1'b1, 2'd1, 16'h0004, 16'h0000, 8'd6},  // R6
    '{2'd3, 4'd1,  4'd1, 1'b0, 1'b0, 3'd0, 5'd0, 1'b0, 2'd0, 16'h0000, 16'h0000, 8'd9},  // R9
    '{2'd0, 4'd4,  4'd2, 1'b0, 1'b1, 3'd1, 5'd0, 1'b0, 2'd0, 16'h0000, 16'h0000, 8'd2},  // R2
    '{2'd0, 4'd6,  4'd2, 1'b0, 1'b1, 3'd2, 5'd0, 1'b1, 2'd0, 16'h0010, 16'h0000, 8'd4},  // R4
    '{2'd3, 4'd6,  4'd2, 1'b0, 1'b0, 3'd0, 5'd0, 1'b0, 2'd0, 16'h0000, 16'h0000, 8'd9},  // R9
    '{2'd0, 4'd9,  4'd2, 1'b0, 1'b1, 3'd0, 5'd0, 1'b0, 2'd0, 16'h0000, 16'h0000, 8'd3},  // R3
    '{2'd0, 4'd12, 4'd2, 1'b0, 1'b1, 3'd0, 5'd0, 1'b0, 2'd0, 16'h0000, 16'h0000, 8'd10}, // R10
    '{2'd1, 4'd5,  4'd2, 1'b0, 1'b1, 3'd1, 5'd7, 1'b1, 2'd2, 16'h33D0, 16'h0000, 8'd10}, // R10
    '{2'd3, 4'd5,  4'd2, 1'b0, 1'b0, 3'd0, 5'd0, 1'b0, 2'd0, 16'h0000, 16'h0000, 8'd9},  // R9
    '{2'd0, 4'd3,  4'd3, 1'b0, 1'b1, 3'd1, 5'd0, 1'b0, 2'd0, 16'h0000, 16'h0000, 8'd2},  // R2
    '{2'd0, 4'd7,  4'd3, 1'b1, 1'b1, 3'd5, 5'd0, 1'b0, 2'd0, 16'h0000, 16'h0008, 8'd11}, // R11
    '{2'd3, 4'd7,  4'd3, 1'b0, 1'b0, 3'd0, 5'd0, 1'b0, 2'd0, 16'h0000, 16'h0000, 8'd9},  // R9
    '{2'd1, 4'd0,  4'd3, 1'b0, 1'b1, 3'd1, 5'd2, 1'b1, 2'd2, 16'h0088, 16'h0000, 8'd5},  // R5
    '{2'd3, 4'd0,  4'd3, 1'b0, 1'b0, 3'd0, 5'd0, 1'b0, 2'd0, 16'h0000, 16'h0000, 8'd9},  // R9
    '{2'd1, 4'd2,  4'd4, 1'b0, 1'b1, 3'd1, 5'd0, 1'b0, 2'd0, 16'h0000, 16'h0000, 8'd2}   // R2
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = '0;
  logic [3:0]  reqSrc = '0;
  logic [3:0]  reqAddr = '0;
  logic        fwdBlocked = 1'b0;
  logic        rspValid, fwdValid;
  logic [2:0]  rspKind;
  logic [3:0]  rspDest, rspAddr, fwdReq, fwdAddr;
  logic [31:0] rspData;
  logic [4:0]  rspAckCnt;
  logic [15:0] rspTargets, fwdMask;
  logic [1:0]  fwdKind;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dir_home_ctrl u_dir_home_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqSrc(reqSrc),
    .reqAddr(reqAddr), .fwdBlocked(fwdBlocked), .rspValid(rspValid), .rspKind(rspKind),
    .rspDest(rspDest), .rspAddr(rspAddr), .rspData(rspData), .rspAckCnt(rspAckCnt),
    .rspTargets(rspTargets), .fwdValid(fwdValid), .fwdKind(fwdKind), .fwdMask(fwdMask),
    .fwdReq(fwdReq), .fwdAddr(fwdAddr)
  );

  function automatic logic [31:0] memWord(input logic [3:0] a);
    return 32'hD000_0000 + 32'(a) * 32'h0000_0101;
  endfunction

  task automatic check(input bit ok, input int tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [3:0] s, input logic [3:0] a,
                       input logic b);
    reqValid = 1'b1; reqKind = k; reqSrc = s; reqAddr = a; fwdBlocked = b;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; fwdBlocked = 1'b0;
  endtask

  task automatic expectOut(input vec_t v);
    int t = int'(v.tag);
    check(rspValid == v.expV, t, "rspValid", 32'(rspValid), 32'(v.expV));
    if (v.expV) begin
      check(rspKind == v.expK, t, "rspKind", 32'(rspKind), 32'(v.expK));
      check(rspDest == v.src, t, "rspDest", 32'(rspDest), 32'(v.src));
      check(rspAddr == v.addr, t, "rspAddr", 32'(rspAddr), 32'(v.addr));
      check(rspAckCnt == v.expA, t, "rspAckCnt", 32'(rspAckCnt), 32'(v.expA));
      check(rspTargets == v.expT, t, "rspTargets", 32'(rspTargets), 32'(v.expT));
      if (v.expK != 3'd3 && v.expK != 3'd4)
        check(rspData == memWord(v.addr), t, "rspData", rspData, memWord(v.addr));
    end
    check(fwdValid == v.expF, t, "fwdValid", 32'(fwdValid), 32'(v.expF));
    if (v.expF) begin
      check(fwdKind == v.expFK, t, "fwdKind", 32'(fwdKind), 32'(v.expFK));
      check(fwdMask == v.expM, t, "fwdMask", 32'(fwdMask), 32'(v.expM));
      check(fwdReq == v.src, t, "fwdReq", 32'(fwdReq), 32'(v.src));
      check(fwdAddr == v.addr, t, "fwdAddr", 32'(fwdAddr), 32'(v.addr));
    end
  endtask

  task automatic run(input vec_t v);
    issue(v.kind, v.src, v.addr, v.blk);
    expectOut(v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: outputs idle after reset
    check(!rspValid, 1, "rspValid after reset", 32'(rspValid), 0);
    check(!fwdValid, 1, "fwdValid after reset", 32'(fwdValid), 0);

    for (int i = 0; i < NUM_VEC; i++) run(VECS[i]);

    // R1: untouched block starts Unowned
    run('{2'd0, 4'd6, 4'd9, 1'b0, 1'b1, 3'd1, 5'd0, 1'b0, 2'd0, 16'h0, 16'h0, 8'd1});
    // R9: busy block rejects GetM and Upgrade, cleared by Done from another node
    run('{2'd0, 4'd1, 4'd5, 1'b0, 1'b1, 3'd1, 5'd0, 1'b0, 2'd0, 16'h0, 16'h0, 8'd2});
    run('{2'd0, 4'd2, 4'd5, 1'b0, 1'b1, 3'd2, 5'd0, 1'b1, 2'd0, 16'h0002, 16'h0, 8'd4});
    run('{2'd1, 4'd3, 4'd5, 1'b0, 1'b1, 3'd4, 5'd0, 1'b0, 2'd0, 16'h0, 16'h0, 8'd9});
    run('{2'd2, 4'd1, 4'd5, 1'b0, 1'b1, 3'd4, 5'd0, 1'b0, 2'd0, 16'h0, 16'h0, 8'd9});
    run('{2'd3, 4'd4, 4'd5, 1'b0, 1'b0, 3'd0, 5'd0, 1'b0, 2'd0, 16'h0, 16'h0, 8'd9});
    run('{2'd1, 4'd3, 4'd5, 1'b0, 1'b1, 3'd1, 5'd2, 1'b1, 2'd2, 16'h0006, 16'h0, 8'd5});
    // R12: idle cycle yields nothing
    @(posedge clk);
    @(negedge clk);
    check(!rspValid, 12, "rspValid on idle", 32'(rspValid), 0);
    check(!fwdValid, 12, "fwdValid on idle", 32'(fwdValid), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual %0d cycles expected fewer", WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule